// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-Out Enable Controller

This block distributes one reference clock onto eighteen outputs and lets a bus host switch each output on or off over a two-wire serial bus. The serial side is a receive-only slave: it samples the bus clock and data lines on a fast system clock, recognises its own address, acknowledges each byte by pulling the data line low, and turns an SMBus-style block write into per-output enable bits. It never transmits data and never holds the bus clock low.

A frame is the address byte, then a command byte and a count byte (both accepted and then disregarded), then data bytes. The data bytes fill enable byte 0, byte 1 and byte 2 in that order. A host may stop after any whole byte, and the bytes written so far remain in effect. An output whose enable bit is set copies the reference clock. An output whose enable bit is clear stays low. A global output-enable pin releases every output to high impedance. Enable changes reach the outputs only while the reference clock is low, so no output ever shows a shortened pulse. A sleep request releases the data line and makes the slave ignore the bus. The programmed enables are kept while it is asserted.

Top module: `clkfan_smbus_ctrl`

## Requirements
- R1: Only the address byte 0xD2 (7-bit address 1101001 with write direction 0) is acknowledged. Any other address byte, including 0xD3 (read) and 0x00 (general call), gets no acknowledge and leaves the enables unchanged.
- R2: Within an addressed frame every byte is acknowledged: the block pulls the data line low during the ninth bus clock and releases it before the next byte. The block has no output on the bus clock.
- R3: The first two bytes after the address are ignored, whatever their values. The third byte after the address is enable byte 0, the fourth is byte 1 and the fifth is byte 2.
- R4: Bit mapping, with 1 = enabled: in byte 0, bit n enables output n (n = 0..7). In byte 1, bit n enables output 8+n. In byte 2, bit 7 enables output 17 and bit 6 enables output 16.
- R5: Data bytes after byte 2 are acknowledged and discarded. Bits 5..0 of byte 2 have no effect.
- R6: A stop after any whole byte keeps every byte written so far, and the bytes not reached keep their old values. A stop or start in the middle of a byte writes nothing from that byte.
- R7: With an output enabled and the output-enable pin high, the output equals the reference clock. With the output disabled, it stays low.
- R8: While the output-enable pin is low, the drive enable of every output is 0 (high impedance).
- R9: After reset all eighteen enables are 1 and the data line is released.
- R10: A new enable value reaches an output only in a cycle in which the reference clock is low. While the reference clock stays high, the outputs keep their old gating.
- R11: While sleep is requested, the data line is released, bus traffic has no effect, and the stored enables are kept after sleep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Power-down request: releases the bus and holds the slave idle |
| scl_in | input | 1 | Serial bus clock as seen on the pin |
| sda_in | input | 1 | Serial bus data as seen on the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| oe_in | input | 1 | Global output enable: 0 puts all outputs into high impedance |
| ref_clk_in | input | 1 | Reference clock to be fanned out |
| fan_val_o | output | NUM_OUT | Value driven on each clock output |
| fan_oe_o | output | NUM_OUT | Drive enable of each clock output (0 = high impedance) |

## Verification
A bus clock edge takes three system cycles to produce its effect: two synchronizer stages, then the receive register. The acknowledge pull and a register write therefore follow the falling edge of the eighth bus clock by three cycles. A new enable then reaches the outputs on the first system edge after that in which the reference clock is low. Each bus clock phase in the bench lasts twenty system cycles. The acknowledge is sampled ten cycles into the ninth high phase. Output values are checked at least two cycles after the reference clock or the output-enable pin changes, and these are combinational paths that need no further wait.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_ACK
  } rx_state_e;
endpackage

// File: rtl/clkfan_bus_sync.sv
module clkfan_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_pipe;
  logic [MSB:0] sda_pipe;
  logic         scl_d;
  logic         sda_d;
  logic         scl_s;

  // The bus idles high, so every stage resets to 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[MSB-1:0], scl_in};
      sda_pipe <= {sda_pipe[MSB-1:0], sda_in};
      scl_d    <= scl_pipe[MSB];
      sda_d    <= sda_pipe[MSB];
    end
  end

  assign scl_s     = scl_pipe[MSB];
  assign sda_s     = sda_pipe[MSB];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/clkfan_smb_rx.sv
module clkfan_smb_rx
  import clkfan_pkg::*;
#(
  parameter logic [6:0]  SLAVE_ADDR = 7'h69,
  parameter int unsigned HDR_BYTES  = 2,
  parameter int unsigned IDX_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_req,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [BYTE_W-1:0] ADDR_WR   = {SLAVE_ADDR, 1'b0};
  localparam logic [IDX_W-1:0]  DATA_BASE = IDX_W'(HDR_BYTES + 1);
  localparam logic [3:0]        LAST_BIT  = 4'(BYTE_W);

  rx_state_e         state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  byte_idx;

  always_ff @(posedge clk) begin
    if (rst || sleep_req) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        state    <= RX_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state    <= RX_SHIFT;
        bit_cnt  <= '0;
        byte_idx <= '0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          RX_SHIFT: begin
            if (scl_rise && bit_cnt < LAST_BIT) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              if (byte_idx == '0 && shreg != ADDR_WR) begin
                state <= RX_IDLE;
              end else begin
                state    <= RX_ACK;
                sda_pull <= 1'b1;
                if (byte_idx >= DATA_BASE) begin
                  wr_stb  <= 1'b1;
                  wr_idx  <= byte_idx - DATA_BASE;
                  wr_data <= shreg;
                end
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= RX_SHIFT;
              bit_cnt  <= '0;
              if (byte_idx != '1) byte_idx <= byte_idx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> $past(scl_fall));

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> !sda_pull);

  // R6
  bit_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= LAST_BIT);
endmodule

// File: rtl/clkfan_en_regs.sv
module clkfan_en_regs
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_OUT = 18,
  parameter int unsigned IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               ref_clk,
  output logic [NUM_OUT-1:0] en_live
);
  localparam int unsigned NUM_BYTES = (NUM_OUT + BYTE_W - 1) / BYTE_W;
  localparam int unsigned TAIL      = NUM_OUT % BYTE_W;

  logic [NUM_OUT-1:0] en_req;
  logic               reserved_unused;

  assign reserved_unused = ^wr_data;

  // A partial last byte uses its top bits.
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
    localparam int unsigned BYTE_K = i / BYTE_W;
    localparam int unsigned BIT_B  = (BYTE_K == NUM_BYTES - 1 && TAIL != 0)
                                     ? (i % BYTE_W) + BYTE_W - TAIL
                                     : (i % BYTE_W);
    always_ff @(posedge clk) begin
      if (rst) begin
        en_req[i] <= 1'b1;
      end else if (wr_stb && wr_idx == IDX_W'(BYTE_K)) begin
        en_req[i] <= wr_data[BIT_B];
      end
    end
  end

  // Enables move to the gates only while the reference clock is low.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_live <= '1;
    end else if (!ref_clk) begin
      en_live <= en_req;
    end
  end

  // R6
  en_req_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_req) |-> $past(wr_stb));

  // R10
  en_apply_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_live) |-> !$past(ref_clk));
endmodule

// File: rtl/clkfan_smbus_ctrl.sv
module clkfan_smbus_ctrl
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_OUT     = 18,
  parameter logic [6:0]  SLAVE_ADDR  = 7'h69,
  parameter int unsigned HDR_BYTES   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned IDX_W       = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sleep_req,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull_o,
  input  logic               oe_in,
  input  logic               ref_clk_in,
  output logic [NUM_OUT-1:0] fan_val_o,
  output logic [NUM_OUT-1:0] fan_oe_o
);
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              wr_stb;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [NUM_OUT-1:0] en_live;

  clkfan_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkfan_smb_rx #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .HDR_BYTES  (HDR_BYTES),
    .IDX_W      (IDX_W)
  ) rx_i (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_pull  (sda_pull_o),
    .wr_stb    (wr_stb),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
  );

  clkfan_en_regs #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ref_clk (ref_clk_in),
    .en_live (en_live)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
    assign fan_val_o[i] = ref_clk_in & en_live[i];
    assign fan_oe_o[i]  = oe_in;
  end

  // R7
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    (fan_val_o & ~en_live) == '0);
endmodule

// File: tb/clkfan_smbus_ctrl_tb.sv
module clkfan_smbus_ctrl_tb_top;
  localparam int N    = 18;
  localparam int HALF = 20;
  localparam int NV   = 6;

  // {addr[69:62], ndata[61:59], data[58:19], ack[18], en[17:0]}
  localparam logic [69:0] VEC [NV] = '{
    {8'hD2, 3'd3, 40'h0FF0800000, 1'b1, 18'h2F00F},
    {8'hD2, 3'd1, 40'hAA00000000, 1'b1, 18'h2F0AA},
    {8'hD0, 3'd2, 40'h5555000000, 1'b0, 18'h2F0AA},
    {8'hD3, 3'd2, 40'h0000000000, 1'b0, 18'h2F0AA},
    {8'h00, 3'd2, 40'h0000000000, 1'b0, 18'h2F0AA},
    {8'hD2, 3'd5, 40'hFFFF7F0000, 1'b1, 18'h1FFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic oe_in = 1'b1;
  logic ref_clk = 1'b0;
  logic sda_line;
  logic sda_pull;
  logic [N-1:0] fan_val;
  logic [N-1:0] fan_oe;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  clkfan_smbus_ctrl dut_i (
    .clk        (clk),
    .rst        (rst),
    .sleep_req  (sleep_req),
    .scl_in     (scl_m),
    .sda_in     (sda_line),
    .sda_pull_o (sda_pull),
    .oe_in      (oe_in),
    .ref_clk_in (ref_clk),
    .fan_val_o  (fan_val),
    .fan_oe_o   (fan_oe)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_cyc(HALF);
    sda_m = 1'b0; wait_cyc(HALF);
    scl_m = 1'b0; wait_cyc(HALF);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_cyc(HALF);
    scl_m = 1'b1; wait_cyc(HALF);
    sda_m = 1'b1; wait_cyc(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wait_cyc(HALF);
    scl_m = 1'b1; wait_cyc(HALF);
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
    sda_m = 1'b1; wait_cyc(HALF);
    scl_m = 1'b1; wait_cyc(HALF / 2);
    acked = (sda_line == 1'b0);
    wait_cyc(HALF / 2);
    scl_m = 1'b0;
  endtask

  // Sends address, command, count and data; returns 1 if all bytes acked,
  // 0 if none were, 2 otherwise.
  task automatic send_frame(input logic [7:0] addr, input logic [7:0] cmd,
                            input int nd, input logic [39:0] data,
                            output logic [1:0] ack_sum);
    logic a;
    int na = 0;
    bus_start();
    send_byte(addr, a); na += int'(a);
    send_byte(cmd, a); na += int'(a);
    send_byte(8'(nd), a); na += int'(a);
    for (int j = 0; j < nd; j++) begin
      send_byte(data[39-8*j -: 8], a); na += int'(a);
    end
    bus_stop();
    ack_sum = (na == nd + 3) ? 2'd1 : (na == 0) ? 2'd0 : 2'd2;
  endtask

  task automatic read_en(output logic [N-1:0] en);
    ref_clk = 1'b1; wait_cyc(2);
    en = fan_val;
    ref_clk = 1'b0; wait_cyc(2);
  endtask

  initial begin
    logic [1:0] acks;
    logic [N-1:0] en;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(5);

    // R9 reset state
    chk("R9 sda released", 32'(sda_pull), 32'd0);
    read_en(en);
    chk("R9 enables all one", 32'(en), 32'h3FFFF);

    // Table of frames
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v][69:62], 8'h00, int'(VEC[v][61:59]), VEC[v][58:19], acks);
      chk($sformatf("R1 R2 R5 ack pattern vec%0d", v), 32'(acks),
          VEC[v][18] ? 32'd1 : 32'd0);
      read_en(en);
      chk($sformatf("R3 R4 R5 R6 enables vec%0d", v), 32'(en), 32'(VEC[v][17:0]));
      chk($sformatf("R7 low phase vec%0d", v), 32'(fan_val), 32'd0);
    end

    // R8 output-enable pin low releases all outputs
    oe_in = 1'b0; wait_cyc(2);
    chk("R8 drive enables off", 32'(fan_oe), 32'd0);
    oe_in = 1'b1; wait_cyc(2);
    chk("R8 drive enables on", 32'(fan_oe), 32'h3FFFF);

    // R3 non-zero command and count are ignored
    send_frame(8'hD2, 8'h5A, 1, 40'hC300000000, acks);
    read_en(en);
    chk("R3 header ignored", 32'(en), 32'h1FFC3);

    // R6 stop in the middle of a data byte writes nothing
    bus_start();
    begin
      logic a;
      send_byte(8'hD2, a);
      send_byte(8'h00, a);
      send_byte(8'h01, a);
    end
    for (int k = 0; k < 4; k++) send_bit(1'b0);
    bus_stop();
    read_en(en);
    chk("R6 mid-byte stop", 32'(en), 32'h1FFC3);

    // R10 enable change held while reference clock is high
    ref_clk = 1'b1; wait_cyc(2);
    send_frame(8'hD2, 8'h00, 1, 40'h0000000000, acks);
    wait_cyc(4);
    chk("R10 held while ref high", 32'(fan_val), 32'h1FFC3);
    ref_clk = 1'b0; wait_cyc(2);
    read_en(en);
    chk("R10 applied after ref low", 32'(en), 32'h1FF00);

    // R11 sleep ignores bus and keeps state
    sleep_req = 1'b1; wait_cyc(2);
    send_frame(8'hD2, 8'h00, 1, 40'h3300000000, acks);
    chk("R11 no ack in sleep", 32'(acks), 32'd0);
    sleep_req = 1'b0; wait_cyc(2);
    read_en(en);
    chk("R11 enables kept", 32'(en), 32'h1FF00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule